// File: doc/BRIEF.md
# Calorimeter Tower Threshold Trigger

This block forms the first trigger stage of a calorimeter. Every tower delivers a stream of digitized energy samples, one new sample per tower whenever `sampleValid` is high. Each tower stream runs through an eight-tap shaping filter with programmable signed coefficients. The filtered pulse first swings positive and then returns through zero. That zero crossing happens at a nearly constant delay after the pulse starts, so it serves as the timing strobe for the tower. At the strobe, the largest raw sample seen since the pulse left the baseline is compared against three energy thresholds. The results are three flag classes: minimum-ionizing, low-energy and high-energy.

Beside the per-tower path, two group sums are formed on every sample. The first adds the rearmost barrel tower rows and the second adds the forward end-cap towers. Each sum has its own threshold. All thresholds and coefficients live in a small write-only configuration register set. Energies are unsigned, with 10 MeV per LSB.

Top module: `calo_tower_trig`

## Requirements
- R1: While reset is low and after reset, all outputs are 0. The thresholds reset to their defaults (R6), and all eight coefficients reset to 0, so no tower can strobe until coefficients are written.
- R2: Each tower's filter output is y[n] = sum over k = 0..7 of c[k]·x[n−k], with signed 8-bit coefficients and unsigned 12-bit samples. A strobe fires when y goes from strictly positive at the previous sample to zero or negative at the current sample. The flags for a sample presented in cycle t appear in cycle t+2.
- R3: A tower arms only on a sample whose filter output is strictly positive while it is idle. Only an armed tower can strobe, so just the first crossing after the pulse leaves the baseline counts.
- R4: After a strobe, a tower spends exactly the next 16 samples in holdoff. During holdoff it neither arms nor strobes, and it can arm again from the 17th sample on.
- R5: At a strobe, the tower's peak is compared against each of the three thresholds. The peak is the maximum raw sample from the arming sample up to the sample before the crossing. A flag is set only if the peak is strictly greater than the threshold.
- R6: The default thresholds, in LSBs, are: minimum-ionizing 12, low-energy 16, high-energy 50, rear-row sum 200, forward sum 12.
- R7: `flagValid` is high for one cycle for each sampled cycle in which at least one tower strobes. The three flag vectors are all-zero in every cycle where `flagValid` is low.
- R8: On every sample, the rear sum (towers 6 and 7) and the forward sum (towers 0 and 1) are each compared against their own threshold, using strictly greater. The results come out with `sumValid`, in the same cycle as that sample's flags. Both hits are 0 when `sumValid` is low.
- R9: A write with `cfgWe` high stores `cfgData` at `cfgAddr`, and the new value is used from the next sample on. The addresses are: 0 minimum-ionizing, 1 low-energy, 2 high-energy, 3 rear sum, 4 forward sum, and 8+k for coefficient k (low 8 bits, two's complement).
- R10: Cycles with `sampleValid` low change no tower state and produce neither `flagValid` nor `sumValid`, whatever is on `sampleData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | New sample for every tower this cycle |
| sampleData | input | 96 | Tower t sample in bits [12t+11:12t], unsigned, 10 MeV/LSB |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register address |
| cfgData | input | 16 | Configuration write data |
| flagValid | output | 1 | Strobe: at least one tower fired |
| flagMip | output | 8 | Per-tower minimum-ionizing flag |
| flagLow | output | 8 | Per-tower low-energy flag |
| flagHigh | output | 8 | Per-tower high-energy flag |
| sumValid | output | 1 | Group-sum results valid |
| rearHit | output | 1 | Rear-row sum above its threshold |
| fwdHit | output | 1 | Forward sum above its threshold |

## Verification
Some properties hold on every cycle, and the assertions check these. The flags are quiet outside `flagValid`, the hits are quiet outside `sumValid`, and both strobes appear exactly two cycles after a presented sample. Every flag strobe also coincides with a sum strobe. Other behaviour depends on the sample history, and only the bench scenarios can show it. This covers the crossing rule and the peak-versus-threshold boundaries (equal never fires). It also covers the exact 16-sample holdoff, ignoring a crossing that was never armed, the default thresholds and the register map. The bench checks these against a sample-by-sample model built from the requirements.

// File: rtl/calo_trig_pkg.sv
package calo_trig_pkg;

  // per-tower strobes from control to datapath
  typedef struct packed {
    logic arm;    // load peak with current sample
    logic track;  // update peak with max
    logic fire;   // latch threshold results
  } twrCtl_t;

  typedef enum logic [1:0] {
    TwIdle  = 2'd0,
    TwArmed = 2'd1,
    TwHold  = 2'd2
  } twrState_e;

  // configuration address map
  localparam int AddrMip  = 0;
  localparam int AddrLow  = 1;
  localparam int AddrHigh = 2;
  localparam int AddrRear = 3;
  localparam int AddrFwd  = 4;
  localparam int CoefBase = 8;

  // default thresholds, 10 MeV per LSB
  localparam int DefMipThr  = 12;
  localparam int DefLowThr  = 16;
  localparam int DefHighThr = 50;
  localparam int DefRearThr = 200;
  localparam int DefFwdThr  = 12;

endpackage

// File: rtl/calo_trig_ctl.sv
module calo_trig_ctl
  import calo_trig_pkg::*;
#(
  parameter int NumTowers  = 8,
  parameter int HoldoffLen = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          newSample,
  input  logic [NumTowers-1:0]          firPos,
  input  logic [NumTowers-1:0]          crossing,
  output twrCtl_t [NumTowers-1:0]       ctlVec
);

  localparam int HoldW = $clog2(HoldoffLen + 1);

  for (genvar t = 0; t < NumTowers; t++) begin : g_twr
    twrState_e        state;
    logic [HoldW-1:0] holdCnt;

    // R3: arm only from idle on positive filter output
    assign ctlVec[t] = '{
      arm:   newSample && (state == TwIdle) && firPos[t],
      track: newSample && (state == TwArmed) && !crossing[t],
      fire:  newSample && (state == TwArmed) && crossing[t]
    };

    always_ff @(posedge clk) begin
      if (!rstN) begin
        state   <= TwIdle;
        holdCnt <= '0;
      end else if (newSample) begin
        unique case (state)
          TwIdle: begin
            if (firPos[t]) state <= TwArmed;
          end
          TwArmed: begin
            if (crossing[t]) begin
              state   <= TwHold;
              holdCnt <= '0;
            end
          end
          TwHold: begin
            // R4: count holdoff samples
            if (holdCnt == HoldW'(HoldoffLen - 1)) state <= TwIdle;
            else                                   holdCnt <= holdCnt + 1'b1;
          end
          default: state <= TwIdle;
        endcase
      end
    end
  end

endmodule

// File: rtl/calo_trig_dp.sv
module calo_trig_dp
  import calo_trig_pkg::*;
#(
  parameter int NumTowers = 8,
  parameter int SampleW   = 12,
  parameter int NumTaps   = 8,
  parameter int CoefW     = 8,
  parameter int CfgW      = 16,
  parameter int AddrW     = 4,
  parameter logic [NumTowers-1:0] RearMask = 8'hC0,
  parameter logic [NumTowers-1:0] FwdMask  = 8'h03
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           sampleValid,
  input  logic [NumTowers*SampleW-1:0]   sampleData,
  input  logic                           cfgWe,
  input  logic [AddrW-1:0]               cfgAddr,
  input  logic [CfgW-1:0]                cfgData,
  input  twrCtl_t [NumTowers-1:0]        ctlVec,
  output logic                           newSample,
  output logic [NumTowers-1:0]           firPos,
  output logic [NumTowers-1:0]           crossing,
  output logic                           flagValid,
  output logic [NumTowers-1:0]           flagMip,
  output logic [NumTowers-1:0]           flagLow,
  output logic [NumTowers-1:0]           flagHigh,
  output logic                           sumValid,
  output logic                           rearHit,
  output logic                           fwdHit
);

  localparam int AccW = SampleW + 1 + CoefW + $clog2(NumTaps);
  localparam int SumW = SampleW + $clog2(NumTowers);

  // ---------------- configuration registers (R9, R6, R1)
  logic [CfgW-1:0]         thrMip, thrLow, thrHigh, thrRear, thrFwd;
  logic signed [CoefW-1:0] coefReg [NumTaps];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrMip  <= CfgW'(DefMipThr);
      thrLow  <= CfgW'(DefLowThr);
      thrHigh <= CfgW'(DefHighThr);
      thrRear <= CfgW'(DefRearThr);
      thrFwd  <= CfgW'(DefFwdThr);
    end else if (cfgWe) begin
      if (cfgAddr == AddrW'(AddrMip))  thrMip  <= cfgData;
      if (cfgAddr == AddrW'(AddrLow))  thrLow  <= cfgData;
      if (cfgAddr == AddrW'(AddrHigh)) thrHigh <= cfgData;
      if (cfgAddr == AddrW'(AddrRear)) thrRear <= cfgData;
      if (cfgAddr == AddrW'(AddrFwd))  thrFwd  <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NumTaps; k++) coefReg[k] <= '0;
    end else if (cfgWe) begin
      for (int k = 0; k < NumTaps; k++) begin
        if (cfgAddr == AddrW'(CoefBase + k)) coefReg[k] <= cfgData[CoefW-1:0];
      end
    end
  end

  // ---------------- per-tower tap line and filter (R2)
  logic [SampleW-1:0] tap0 [NumTowers];

  for (genvar t = 0; t < NumTowers; t++) begin : g_fir
    logic [SampleW-1:0]     taps [NumTaps];
    logic signed [AccW-1:0] firOut;
    logic signed [AccW-1:0] xs, cs;
    logic                   prevPos;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int k = 0; k < NumTaps; k++) taps[k] <= '0;
        prevPos <= 1'b0;
      end else if (sampleValid) begin
        taps[0] <= sampleData[t*SampleW +: SampleW];
        for (int k = 1; k < NumTaps; k++) taps[k] <= taps[k-1];
        prevPos <= firPos[t];
      end
    end

    always_comb begin
      firOut = '0;
      xs     = '0;
      cs     = '0;
      for (int k = 0; k < NumTaps; k++) begin
        xs     = AccW'(signed'({1'b0, taps[k]}));
        cs     = AccW'(coefReg[k]);
        firOut = firOut + xs * cs;
      end
    end

    assign firPos[t]   = !firOut[AccW-1] && (firOut != '0);
    assign crossing[t] = prevPos && !firPos[t];
    assign tap0[t]     = taps[0];
  end

  // ---------------- peak tracking (R5)
  logic [SampleW-1:0] peak [NumTowers];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NumTowers; t++) peak[t] <= '0;
    end else begin
      for (int t = 0; t < NumTowers; t++) begin
        if (ctlVec[t].arm)                              peak[t] <= tap0[t];
        else if (ctlVec[t].track && tap0[t] > peak[t])  peak[t] <= tap0[t];
      end
    end
  end

  // ---------------- group sums (R8)
  logic [SumW-1:0] rearSum, fwdSum;

  always_comb begin
    rearSum = '0;
    fwdSum  = '0;
    for (int t = 0; t < NumTowers; t++) begin
      if (RearMask[t]) rearSum = rearSum + SumW'(tap0[t]);
      if (FwdMask[t])  fwdSum  = fwdSum  + SumW'(tap0[t]);
    end
  end

  // ---------------- output registers (R5, R7, R8)
  logic [NumTowers-1:0] fireVec;
  for (genvar t = 0; t < NumTowers; t++) begin : g_fire
    assign fireVec[t] = ctlVec[t].fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newSample <= 1'b0;
      flagValid <= 1'b0;
      flagMip   <= '0;
      flagLow   <= '0;
      flagHigh  <= '0;
      sumValid  <= 1'b0;
      rearHit   <= 1'b0;
      fwdHit    <= 1'b0;
    end else begin
      newSample <= sampleValid;
      flagValid <= |fireVec;
      for (int t = 0; t < NumTowers; t++) begin
        flagMip[t]  <= fireVec[t] && (CfgW'(peak[t]) > thrMip);
        flagLow[t]  <= fireVec[t] && (CfgW'(peak[t]) > thrLow);
        flagHigh[t] <= fireVec[t] && (CfgW'(peak[t]) > thrHigh);
      end
      sumValid <= newSample;
      rearHit  <= newSample && (CfgW'(rearSum) > thrRear);
      fwdHit   <= newSample && (CfgW'(fwdSum) > thrFwd);
    end
  end

endmodule

// File: rtl/calo_tower_trig.sv
module calo_tower_trig
  import calo_trig_pkg::*;
#(
  parameter int NumTowers  = 8,
  parameter int SampleW    = 12,
  parameter int NumTaps    = 8,
  parameter int CoefW      = 8,
  parameter int CfgW       = 16,
  parameter int AddrW      = 4,
  parameter int HoldoffLen = 16,
  parameter logic [NumTowers-1:0] RearMask = 8'hC0,
  parameter logic [NumTowers-1:0] FwdMask  = 8'h03
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleValid,
  input  logic [NumTowers*SampleW-1:0] sampleData,
  input  logic                         cfgWe,
  input  logic [AddrW-1:0]             cfgAddr,
  input  logic [CfgW-1:0]              cfgData,
  output logic                         flagValid,
  output logic [NumTowers-1:0]         flagMip,
  output logic [NumTowers-1:0]         flagLow,
  output logic [NumTowers-1:0]         flagHigh,
  output logic                         sumValid,
  output logic                         rearHit,
  output logic                         fwdHit
);

  twrCtl_t [NumTowers-1:0] ctlVec;
  logic                    newSample;
  logic [NumTowers-1:0]    firPos;
  logic [NumTowers-1:0]    crossing;

  calo_trig_ctl #(
    .NumTowers (NumTowers),
    .HoldoffLen(HoldoffLen)
  ) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .newSample(newSample),
    .firPos   (firPos),
    .crossing (crossing),
    .ctlVec   (ctlVec)
  );

  calo_trig_dp #(
    .NumTowers(NumTowers),
    .SampleW  (SampleW),
    .NumTaps  (NumTaps),
    .CoefW    (CoefW),
    .CfgW     (CfgW),
    .AddrW    (AddrW),
    .RearMask (RearMask),
    .FwdMask  (FwdMask)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sampleData (sampleData),
    .cfgWe      (cfgWe),
    .cfgAddr    (cfgAddr),
    .cfgData    (cfgData),
    .ctlVec     (ctlVec),
    .newSample  (newSample),
    .firPos     (firPos),
    .crossing   (crossing),
    .flagValid  (flagValid),
    .flagMip    (flagMip),
    .flagLow    (flagLow),
    .flagHigh   (flagHigh),
    .sumValid   (sumValid),
    .rearHit    (rearHit),
    .fwdHit     (fwdHit)
  );

endmodule

// File: rtl/calo_tower_trig_chk.sv
module calo_tower_trig_chk #(
  parameter int NumTowers = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sampleValid,
  input logic                 flagValid,
  input logic [NumTowers-1:0] flagMip,
  input logic [NumTowers-1:0] flagLow,
  input logic [NumTowers-1:0] flagHigh,
  input logic                 sumValid,
  input logic                 rearHit,
  input logic                 fwdHit
);

  // R7
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flagValid |-> (flagMip == '0 && flagLow == '0 && flagHigh == '0));

  // R8
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sumValid |-> (!rearHit && !fwdHit));

  // R2
  flag_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |-> $past(sampleValid, 2));

  // R10
  sum_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    sumValid |-> $past(sampleValid, 2));

  // R8
  flag_sum_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |-> sumValid);

endmodule

bind calo_tower_trig calo_tower_trig_chk #(.NumTowers(NumTowers)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .flagValid  (flagValid),
  .flagMip    (flagMip),
  .flagLow    (flagLow),
  .flagHigh   (flagHigh),
  .sumValid   (sumValid),
  .rearHit    (rearHit),
  .fwdHit     (fwdHit)
);

// File: tb/calo_tower_trig_tb_top.sv
module calo_tower_trig_tb_top;

  localparam int NT = 8;
  localparam int SW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [NT*SW-1:0] sampleData = '0;
  logic          cfgWe = 1'b0;
  logic [3:0]    cfgAddr = '0;
  logic [15:0]   cfgData = '0;
  logic          flagValid, sumValid, rearHit, fwdHit;
  logic [NT-1:0] flagMip, flagLow, flagHigh;

  always #5 clk = ~clk;

  calo_tower_trig dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .flagValid(flagValid), .flagMip(flagMip), .flagLow(flagLow), .flagHigh(flagHigh),
    .sumValid(sumValid), .rearHit(rearHit), .fwdHit(fwdHit)
  );

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  // ---------------- reference model state
  int hist [NT][8];
  int prevF [NT];
  int stM [NT];      // 0 idle, 1 armed, 2 hold
  int cntM [NT];
  int pkM [NT];
  int cM [8];
  int thMip, thLow, thHigh, thRear, thFwd;
  int cur [NT];
  int mip2Cnt;

  task automatic check(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelInit();
    for (int t = 0; t < NT; t++) begin
      for (int k = 0; k < 8; k++) hist[t][k] = 0;
      prevF[t] = 0; stM[t] = 0; cntM[t] = 0; pkM[t] = 0; cur[t] = 0;
    end
    for (int k = 0; k < 8; k++) cM[k] = 0;
    thMip = 12; thLow = 16; thHigh = 50; thRear = 200; thFwd = 12;
  endtask

  task automatic doReset();
    rstN = 1'b0; sampleValid = 1'b0; cfgWe = 1'b0; sampleData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    modelInit();
  endtask

  task automatic cfgWrite(int addr, int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'(addr); cfgData = 16'(data);
    @(negedge clk);
    cfgWe = 1'b0;
    if (addr == 0) thMip = data;
    else if (addr == 1) thLow = data;
    else if (addr == 2) thHigh = data;
    else if (addr == 3) thRear = data;
    else if (addr == 4) thFwd = data;
    else if (addr >= 8) cM[addr-8] = (data & 8'h80) ? (data & 8'hFF) - 256 : (data & 8'hFF);
  endtask

  // present cur[] as one sample, update model, compare outputs
  task automatic step(string req);
    int eFv, eMip, eLow, eHigh, eRear, eFwd, f;
    eFv = 0; eMip = 0; eLow = 0; eHigh = 0;
    for (int t = 0; t < NT; t++) begin
      for (int k = 7; k > 0; k--) hist[t][k] = hist[t][k-1];
      hist[t][0] = cur[t];
      f = 0;
      for (int k = 0; k < 8; k++) f += cM[k] * hist[t][k];
      if (stM[t] == 0) begin
        if (f > 0) begin stM[t] = 1; pkM[t] = cur[t]; end
      end else if (stM[t] == 1) begin
        if (prevF[t] > 0 && f <= 0) begin
          eFv = 1;
          if (pkM[t] > thMip)  eMip  |= (1 << t);
          if (pkM[t] > thLow)  eLow  |= (1 << t);
          if (pkM[t] > thHigh) eHigh |= (1 << t);
          stM[t] = 2; cntM[t] = 0;
        end else if (cur[t] > pkM[t]) pkM[t] = cur[t];
      end else begin
        if (cntM[t] == 15) stM[t] = 0;
        else cntM[t]++;
      end
      prevF[t] = f;
    end
    eRear = (cur[6] + cur[7] > thRear) ? 1 : 0;
    eFwd  = (cur[0] + cur[1] > thFwd) ? 1 : 0;

    @(negedge clk);
    for (int t = 0; t < NT; t++) sampleData[t*SW +: SW] = 12'(cur[t]);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
    check(req, "flagValid", int'(flagValid), eFv);
    check(req, "flagMip",  int'(flagMip),  eMip);
    check(req, "flagLow",  int'(flagLow),  eLow);
    check(req, "flagHigh", int'(flagHigh), eHigh);
    check("R8", "sumValid", int'(sumValid), 1);
    check("R8", "rearHit", int'(rearHit), eRear);
    check("R8", "fwdHit",  int'(fwdHit),  eFwd);
    if (flagMip[2]) mip2Cnt++;
  endtask

  task automatic clearCur();
    for (int t = 0; t < NT; t++) cur[t] = 0;
  endtask

  task automatic flush(int n);
    clearCur();
    for (int i = 0; i < n; i++) step("R2");
  endtask

  task automatic progCoefs();
    // bipolar shaper: 2,1,0,-1,-2,-1,0,0 (R9 coefficient addresses 8..15)
    cfgWrite(8, 2);  cfgWrite(9, 1);  cfgWrite(10, 0); cfgWrite(11, 16'hFF);
    cfgWrite(12, 16'hFE); cfgWrite(13, 16'hFF); cfgWrite(14, 0); cfgWrite(15, 0);
  endtask

  // ---------------- scenarios
  task automatic testReset();
    doReset();
    @(negedge clk);
    check("R1", "flagValid after reset", int'(flagValid), 0);
    check("R1", "flags after reset", int'({flagMip, flagLow, flagHigh}), 0);
    check("R1", "sums after reset", int'({sumValid, rearHit, fwdHit}), 0);
    // r1_ coefficients zero: a large pulse must not strobe
    clearCur(); cur[3] = 900; step("R1");
    flush(4);
  endtask

  task automatic testDefaults();
    progCoefs();
    flush(2);
    clearCur(); cur[0] = 20; cur[6] = 150; cur[7] = 150;
    step("R6");
    check("R6", "rearHit 300>200", int'(rearHit), 1);
    check("R6", "fwdHit 20>12", int'(fwdHit), 1);
    clearCur(); step("R6");
    step("R6");
    check("R6", "flagMip default", int'(flagMip), 8'hC1);
    check("R6", "flagLow default", int'(flagLow), 8'hC1);
    check("R6", "flagHigh default", int'(flagHigh), 8'hC0);
    flush(20);
  endtask

  task automatic testBoundary();
    cfgWrite(0, 30); cfgWrite(1, 40); cfgWrite(2, 100);
    cfgWrite(3, 100); cfgWrite(4, 70);
    clearCur(); cur[0] = 30; cur[1] = 40; cur[2] = 100; cur[3] = 101;
    step("R9");
    check("R5", "fwd equal not above", int'(fwdHit), 0);
    clearCur(); step("R5");
    step("R5");
    check("R5", "mip boundary", int'(flagMip[3:0]), 4'b1110);
    check("R5", "low boundary", int'(flagLow[3:0]), 4'b1100);
    check("R5", "high boundary", int'(flagHigh[3:0]), 4'b1000);
    flush(20);
    clearCur(); cur[6] = 60; cur[7] = 41; step("R8");
    check("R8", "rear 101>100", int'(rearHit), 1);
    flush(20);
  endtask

  task automatic testHoldoff();
    mip2Cnt = 0;
    for (int i = 0; i < 40; i++) begin
      clearCur();
      if (i == 0) cur[2] = 60;
      if (i == 5) cur[2] = 80;
      if (i == 19) cur[2] = 70;
      step("R4");
    end
    check("R4", "strobes with holdoff", mip2Cnt, 2);
    mip2Cnt = 0;
    for (int i = 0; i < 40; i++) begin
      clearCur();
      if (i == 0) cur[2] = 60;
      if (i == 17) cur[2] = 90;
      step("R3");
    end
    check("R3", "unarmed crossing ignored", mip2Cnt, 1);
  endtask

  task automatic testIdle();
    clearCur(); cur[4] = 200; step("R10");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      sampleData = {3{32'(i * 32'h9E3779B9)}};
      check("R10", "flagValid idle", int'(flagValid), 0);
      check("R10", "sumValid idle", int'(sumValid), 0);
    end
    clearCur(); step("R10");
    step("R10");
    check("R10", "strobe after gap", int'(flagMip[4]), 1);
    flush(20);
  endtask

  task automatic testMix();
    int lcg;
    lcg = 12345;
    for (int i = 0; i < 300; i++) begin
      for (int t = 0; t < NT; t++) begin
        lcg = lcg * 1103515245 + 12345;
        cur[t] = (((lcg >>> 16) & 7) == 0) ? ((lcg >>> 8) & 511) : 0;
      end
      step("R7");
    end
    flush(20);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nBad++; nChk++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
        $display("test done: total=%0d bad=%0d", nChk, nBad);
        $finish;
      end
    end
  end

  initial begin
    testReset();
    testDefaults();
    testBoundary();
    testHoldoff();
    testIdle();
    testMix();
    finished = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule